// File: doc/BRIEF.md
# DSP-mode stereo audio serializer

This block drives the serial data line of a link to a stereo DAC that runs the interface as clock master. The DAC supplies the bit clock and a short frame-alignment pulse. All logic in the block runs on the incoming bit clock. Each frame, a client hands over a signed 16-bit left sample and a signed 16-bit right sample through a valid/ready handshake in the bit-clock domain. The pair is held until the next frame pulse. The block then shifts out the left word, most significant bit first, and follows it with the right word in the next bit period, with no gap between them.

The data line changes only on falling edges of the bit clock, so it is stable when the DAC samples it on rising edges. The delay from the frame pulse to the left MSB is fixed at build time. It is either one or two rising edges. Outside the 32 data bit periods, and whenever the block is disabled or in reset, the line is held low. If a frame begins before the client has offered a new pair, the block sends the previous pair again and raises a one-cycle underrun flag.

With a 12 MHz bit clock and a 48 kHz frame rate, there are 250 bit periods per frame. Only the first 32 after the start offset carry data.

Top module: `aud_dsp_tx`

## Requirements
- R1: While rst_n is low, sdata is 0, in_ready is 1 and underrun is 0.
- R2: A frame start is a rising edge of bclk at which enable is 1 and lrc is 1, after lrc was 0 at the previous rising edge. If lrc stays high for several cycles, that still counts as one frame start.
- R3: Call the rising edge that detects the frame start edge 0. With START_DELAY=1 the left MSB is valid at rising edge 1. With START_DELAY=2 it is valid at rising edge 2, and sdata is 0 at rising edge 1.
- R4: Starting at the MSB position, sdata carries the left word and then the right word, 32 consecutive bit periods in all, each word MSB first.
- R5: After the last right-word bit, sdata stays 0 until the next frame start.
- R6: sdata changes only on falling edges of bclk. Its value a quarter period before a rising edge equals its value a quarter period after that edge.
- R7: in_ready is 1 exactly when the holding register is empty. A pair is accepted at a rising edge where in_valid and in_ready are both 1, and in_ready is 0 from that edge on. A frame start moves the held pair into the shifter, and in_ready is 1 from that edge on.
- R8: If a frame starts while the holding register is empty, the previously held pair is sent again and underrun is 1 for exactly one cycle, beginning at the frame-start edge. Before any pair has been accepted, the held pair is zero.
- R9: While enable is 0, sdata is 0 and lrc pulses start no frame. A pair accepted during that time stays held: in_ready stays 0 and no underrun is raised. That pair is sent at the first frame after enable returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock from the DAC; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | When 0, the output is forced low and frame starts are ignored |
| lrc | input | 1 | Frame-alignment pulse from the DAC, changes on falling edges |
| in_valid | input | 1 | The client offers a sample pair |
| in_ready | output | 1 | The holding register is empty and can take a pair |
| in_left | input | SAMPLE_W | Left-channel sample, two's complement |
| in_right | input | SAMPLE_W | Right-channel sample, two's complement |
| sdata | output | 1 | Serial data to the DAC |
| underrun | output | 1 | One-cycle pulse when a frame started without a fresh pair |

## Verification
The bench plays the DAC role and runs two instances, one for each start offset, side by side. A design with the offset one edge off would shift the rebuilt words by one bit. A design that left a gap between the channels, or kept shifting after 32 bits, would corrupt the right word or leave bits set in the tail that should be low.

A long lrc pulse checks that a design which treats the level as a start would restart the frame and garble the words. The bench also covers three other corner cases:
- A frame with no new pair, where a wrong design would send zeros or skip the underrun pulse.
- A frame while disabled, where a wrong design would send data or consume the held pair.
- Sampling on both sides of each rising edge, which catches an output that changes on the wrong edge.

// File: rtl/aud_ser_pkg.sv
`timescale 1ns/1ps
package aud_ser_pkg;
   // Largest start offset supported, in rising edges after detection
   localparam int unsigned MAX_START_DELAY = 2;
   localparam int unsigned MIN_SAMPLE_W    = 2;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LEAD = 2'd1,
      PH_DATA = 2'd2
   } tx_phase_e;
endpackage

// File: rtl/aud_ser_hold.sv
`timescale 1ns/1ps
module aud_ser_hold #(
   parameter int unsigned SAMPLE_W = 16
) (
   input  logic                  bclk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [SAMPLE_W-1:0]   in_left,
   input  logic [SAMPLE_W-1:0]   in_right,
   input  logic                  take,
   output logic                  in_ready,
   output logic                  underrun,
   output logic [2*SAMPLE_W-1:0] pair_out
);
   localparam int unsigned PAIR_W = 2 * SAMPLE_W;

   logic              fresh;
   logic              accept;
   logic [PAIR_W-1:0] held;

   assign in_ready = ~fresh;
   assign accept   = in_valid & ~fresh;
   assign pair_out = held;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         held     <= '0;
         fresh    <= 1'b0;
         underrun <= 1'b0;
      end else begin
         underrun <= take & ~fresh;
         if (accept) begin
            held  <= {in_left, in_right};
            fresh <= 1'b1;
         end else if (take) begin
            fresh <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/aud_ser_frame.sv
`timescale 1ns/1ps
module aud_ser_frame
   import aud_ser_pkg::*;
#(
   parameter int unsigned SAMPLE_W    = 16,
   parameter int unsigned START_DELAY = 1
) (
   input  logic bclk,
   input  logic rst_n,
   input  logic enable,
   input  logic lrc,
   output logic start,
   output logic shift_en,
   output logic launch
);
   localparam int unsigned FRAME_BITS = 2 * SAMPLE_W;
   localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
   localparam int unsigned LEAD_CYC   = START_DELAY - 1;
   localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(FRAME_BITS - 1);

   logic             lrc_q;
   tx_phase_e        phase;
   logic             lead_last;
   logic [CNT_W-1:0] bit_cnt;

   assign start    = enable & lrc & ~lrc_q;
   assign launch   = (phase == PH_DATA);
   assign shift_en = (phase == PH_DATA) & ~start;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) lrc_q <= 1'b0;
      else        lrc_q <= lrc;
   end

   generate
      if (LEAD_CYC == 0) begin : g_nolead
         assign lead_last = 1'b1;
      end else begin : g_lead
         localparam int unsigned LEAD_W = (LEAD_CYC > 1) ? $clog2(LEAD_CYC) : 1;
         localparam logic [LEAD_W-1:0] LEAD_LAST = LEAD_W'(LEAD_CYC - 1);
         logic [LEAD_W-1:0] lead_cnt;
         always_ff @(posedge bclk or negedge rst_n) begin
            if (!rst_n)                 lead_cnt <= '0;
            else if (start)             lead_cnt <= '0;
            else if (phase == PH_LEAD)  lead_cnt <= lead_cnt + 1'b1;
         end
         assign lead_last = (lead_cnt == LEAD_LAST);
      end
   endgenerate

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         bit_cnt <= '0;
      end else if (!enable) begin
         phase   <= PH_IDLE;
      end else if (start) begin
         phase   <= (LEAD_CYC == 0) ? PH_DATA : PH_LEAD;
         bit_cnt <= CNT_FIRST;
      end else begin
         case (phase)
            PH_LEAD: if (lead_last) phase <= PH_DATA;
            PH_DATA: begin
               if (bit_cnt == '0) phase   <= PH_IDLE;
               else               bit_cnt <= bit_cnt - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/aud_ser_shift.sv
`timescale 1ns/1ps
module aud_ser_shift #(
   parameter int unsigned SAMPLE_W = 16
) (
   input  logic                  bclk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic                  load,
   input  logic [2*SAMPLE_W-1:0] load_data,
   input  logic                  shift_en,
   input  logic                  launch,
   output logic                  sdata
);
   localparam int unsigned PAIR_W = 2 * SAMPLE_W;

   logic [PAIR_W-1:0] sreg;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n)        sreg <= '0;
      else if (load)     sreg <= load_data;
      else if (shift_en) sreg <= {sreg[PAIR_W-2:0], 1'b0};
   end

   // Launch register on the falling edge keeps the line steady at each rising edge
   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) sdata <= 1'b0;
      else        sdata <= enable & launch & sreg[PAIR_W-1];
   end
endmodule

// File: rtl/aud_dsp_tx.sv
`timescale 1ns/1ps
module aud_dsp_tx
   import aud_ser_pkg::*;
#(
   parameter int unsigned SAMPLE_W    = 16,
   parameter int unsigned START_DELAY = 1
) (
   input  logic                bclk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                lrc,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   output logic                sdata,
   output logic                underrun
);
   localparam int unsigned PAIR_W = 2 * SAMPLE_W;

   generate
      if (START_DELAY < 1 || START_DELAY > MAX_START_DELAY) begin : g_bad_delay
         $error("aud_dsp_tx: START_DELAY must be 1 or 2");
      end
      if (SAMPLE_W < MIN_SAMPLE_W) begin : g_bad_width
         $error("aud_dsp_tx: SAMPLE_W too small");
      end
   endgenerate

   logic              start;
   logic              shift_en;
   logic              launch;
   logic [PAIR_W-1:0] pair;

   aud_ser_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
      .bclk     (bclk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_left  (in_left),
      .in_right (in_right),
      .take     (start),
      .in_ready (in_ready),
      .underrun (underrun),
      .pair_out (pair)
   );

   aud_ser_frame #(.SAMPLE_W(SAMPLE_W), .START_DELAY(START_DELAY)) u_frame (
      .bclk     (bclk),
      .rst_n    (rst_n),
      .enable   (enable),
      .lrc      (lrc),
      .start    (start),
      .shift_en (shift_en),
      .launch   (launch)
   );

   aud_ser_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
      .bclk      (bclk),
      .rst_n     (rst_n),
      .enable    (enable),
      .load      (start),
      .load_data (pair),
      .shift_en  (shift_en),
      .launch    (launch),
      .sdata     (sdata)
   );
endmodule

// File: rtl/aud_dsp_tx_chk.sv
`timescale 1ns/1ps
module aud_dsp_tx_chk (
   input logic bclk,
   input logic rst_n,
   input logic enable,
   input logic lrc,
   input logic in_valid,
   input logic in_ready,
   input logic sdata,
   input logic underrun
);
   // R7
   accept_drops_ready_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R7
   ready_rises_on_start_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      $rose(in_ready) |-> $past(lrc && enable));

   // R8
   underrun_single_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      underrun |=> !underrun);

   // R8
   underrun_cause_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      underrun |-> $past(in_ready && lrc && enable));

   // R9
   disabled_low_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      (!enable && $past(!enable)) |-> !sdata);
endmodule

bind aud_dsp_tx aud_dsp_tx_chk u_chk (
   .bclk     (bclk),
   .rst_n    (rst_n),
   .enable   (enable),
   .lrc      (lrc),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .sdata    (sdata),
   .underrun (underrun)
);

// File: tb/sim_aud_dsp_tx.sv
`timescale 1ns/1ps
module sim_aud_dsp_tx;
   localparam int CLK_PERIOD = 20;
   localparam int FRAME      = 250;
   localparam int W          = 16;
   localparam int NSAMP      = 38;

   logic         bclk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enable = 1'b0;
   logic         lrc = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_left = '0;
   logic [W-1:0] in_right = '0;
   logic         ready0, ready1, sd0, sd1, ur0, ur1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) bclk = ~bclk;

   aud_dsp_tx #(.SAMPLE_W(W), .START_DELAY(1)) u0 (
      .bclk(bclk), .rst_n(rst_n), .enable(enable), .lrc(lrc),
      .in_valid(in_valid), .in_ready(ready0), .in_left(in_left), .in_right(in_right),
      .sdata(sd0), .underrun(ur0));

   aud_dsp_tx #(.SAMPLE_W(W), .START_DELAY(2)) u1 (
      .bclk(bclk), .rst_n(rst_n), .enable(enable), .lrc(lrc),
      .in_valid(in_valid), .in_ready(ready1), .in_left(in_left), .in_right(in_right),
      .sdata(sd1), .underrun(ur1));

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic offer(input logic [W-1:0] l, input logic [W-1:0] r);
      @(posedge bclk); #(CLK_PERIOD/4);
      check(ready0 && ready1, "R7", "ready before offer", {30'd0, ready1, ready0}, 32'h3);
      in_valid = 1'b1; in_left = l; in_right = r;
      @(posedge bclk); #(CLK_PERIOD/4);
      in_valid = 1'b0;
      check(!ready0 && !ready1, "R7", "ready after accept", {30'd0, ready1, ready0}, 32'h0);
   endtask

   // One DAC frame; the pulse stays high for hold_hi rising edges
   task automatic run_frame(input logic [W-1:0] el, input logic [W-1:0] er,
                            input bit exp_ur, input bit en_exp, input int hold_hi,
                            input string tag);
      logic [NSAMP:0] s0a, s0b, s1a, s1b;
      logic [W-1:0]   l0, r0, l1, r1, xl, xr;
      logic           tail0, tail1, idle_bad;
      s0a = '0; s0b = '0; s1a = '0; s1b = '0;
      xl = en_exp ? el : '0;
      xr = en_exp ? er : '0;
      @(negedge bclk); lrc = 1'b1;
      for (int k = 1; k <= NSAMP; k++) begin
         @(negedge bclk);
         if (k == hold_hi) lrc = 1'b0;
         #(CLK_PERIOD/4);
         s0a[k] = sd0; s1a[k] = sd1;
         if (k == 1)
            check(ur0 == exp_ur && ur1 == exp_ur, {tag, " R8"}, "underrun at start",
                  {30'd0, ur1, ur0}, {30'd0, exp_ur, exp_ur});
         if (k == 2) begin
            check(!ur0 && !ur1, {tag, " R8"}, "underrun one cycle", {30'd0, ur1, ur0}, 32'h0);
            check(ready0 == en_exp && ready1 == en_exp, {tag, " R7"}, "ready after start",
                  {30'd0, ready1, ready0}, {30'd0, en_exp, en_exp});
         end
         #(CLK_PERIOD/2);
         s0b[k] = sd0; s1b[k] = sd1;
      end
      for (int i = 0; i < W; i++) begin
         l0[W-1-i] = s0a[1+i];  r0[W-1-i] = s0a[1+W+i];
         l1[W-1-i] = s1a[2+i];  r1[W-1-i] = s1a[2+W+i];
      end
      tail0 = 1'b0; tail1 = 1'b0;
      for (int k = 2*W+1; k <= NSAMP; k++) tail0 |= s0a[k];
      for (int k = 2*W+2; k <= NSAMP; k++) tail1 |= s1a[k];
      check(l0 == xl, {tag, " R3 R4"}, "left word delay1", {16'd0, l0}, {16'd0, xl});
      check(r0 == xr, {tag, " R4"}, "right word delay1", {16'd0, r0}, {16'd0, xr});
      check(l1 == xl, {tag, " R3 R4"}, "left word delay2", {16'd0, l1}, {16'd0, xl});
      check(r1 == xr, {tag, " R4"}, "right word delay2", {16'd0, r1}, {16'd0, xr});
      check(!s1a[1], {tag, " R3"}, "lead bit delay2 low", {31'd0, s1a[1]}, 32'h0);
      check(!tail0 && !tail1, {tag, " R5"}, "tail after words", {30'd0, tail1, tail0}, 32'h0);
      check(s0a == s0b && s1a == s1b, {tag, " R6"}, "stable across rising edge",
            s0a[31:0] ^ s0b[31:0], 32'h0);
      idle_bad = 1'b0;
      for (int k = 0; k < FRAME - NSAMP - 4; k++) begin
         @(negedge bclk); #(CLK_PERIOD/4);
         idle_bad |= sd0 | sd1;
      end
      check(!idle_bad, {tag, " R5"}, "idle gap low", {31'd0, idle_bad}, 32'h0);
   endtask

   task automatic t_reset();
      repeat (3) @(posedge bclk);
      #(CLK_PERIOD/4);
      check(!sd0 && !sd1, "R1", "sdata in reset", {30'd0, sd1, sd0}, 32'h0);
      check(ready0 && ready1, "R1", "ready in reset", {30'd0, ready1, ready0}, 32'h3);
      check(!ur0 && !ur1, "R1", "underrun in reset", {30'd0, ur1, ur0}, 32'h0);
      rst_n = 1'b1;
      @(posedge bclk); #(CLK_PERIOD/4);
      enable = 1'b1;
   endtask

   task automatic t_first_underrun();
      run_frame(16'h0000, 16'h0000, 1'b1, 1'b1, 1, "R8");
   endtask

   task automatic t_patterns();
      offer(16'h8001, 16'h7FFE);
      run_frame(16'h8001, 16'h7FFE, 1'b0, 1'b1, 1, "R4");
      offer(16'hFFFF, 16'h0000);
      run_frame(16'hFFFF, 16'h0000, 1'b0, 1'b1, 1, "R4");
      offer(16'hA5C3, 16'h3C5A);
      run_frame(16'hA5C3, 16'h3C5A, 1'b0, 1'b1, 1, "R4");
   endtask

   task automatic t_resend();
      run_frame(16'hA5C3, 16'h3C5A, 1'b1, 1'b1, 1, "R8");
   endtask

   task automatic t_disable();
      @(posedge bclk); #(CLK_PERIOD/4);
      enable = 1'b0;
      offer(16'h1234, 16'h5678);
      run_frame(16'h1234, 16'h5678, 1'b0, 1'b0, 1, "R9");
      @(posedge bclk); #(CLK_PERIOD/4);
      enable = 1'b1;
      run_frame(16'h1234, 16'h5678, 1'b0, 1'b1, 1, "R9");
   endtask

   task automatic t_long_pulse();
      offer(16'h0F0F, 16'hF0F0);
      run_frame(16'h0F0F, 16'hF0F0, 1'b0, 1'b1, 3, "R2");
   endtask

   initial begin
      repeat (200000) @(posedge bclk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_first_underrun();
      t_patterns();
      t_resend();
      t_disable();
      t_long_pulse();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule